// File: doc/BRIEF.md
# Merged Multiply-Accumulate Compression Tree

This block computes an unsigned 8x8 product plus a 16-bit addend in one pass. The addend is not summed after the multiplier. Its bits are fed into the compressor inputs that the slanted shape of the partial-product matrix leaves empty. A single carry-propagate adder then finishes the sum, so no second carry chain follows the product.

Eight AND-array rows are reduced in two levels of 4:2 compressors. In the first level, a low group and a high group each fold four rows into two. The second level folds the resulting four rows into two. Twelve addend bits enter the first level and four enter the second. One addend bit lands in a column that is already full. Two six-input compressors at adjacent weights absorb it, and their spare carries are passed sideways into the neighbouring column.

A registered wrapper turns the datapath into an accumulator. It feeds the low sixteen bits of its 17-bit register back in as the addend, and it has a synchronous clear and a load enable.

Top module: `mac_merge_acc`

## Requirements
- R1: For every pair of 8-bit operands and any 16-bit addend, the combinational core result equals operand_a*operand_b + addend as a 17-bit unsigned value.
- R2: Each addend bit k adds exactly 2^k to the core result, both with zero operands and with both operands at 255.
- R3: With both operands at 255 and the addend at all ones, the core result is 130560 and bit 16 is set.
- R4: While reset is low, the accumulator register reads zero, and it still reads zero on the first cycle after release.
- R5: With clear low and enable high, on each rising edge the register loads a_i*b_i plus its own previous low 16 bits.
- R6: With clear and enable both low, the register keeps its value.
- R7: With clear high, the register becomes zero on the next edge, whatever the enable level.
- R8: Bit 16 of the register is never fed back. After an overflow into bit 16, the next load uses only the low 16 bits, and the register never exceeds 130560.
- R9: No sideways carry leaves the top column of any compressor row (spill flag always 0).
- R10: The six-input compressor satisfies a+b+c+d+cin1+cin2 = sum + 2*(carry+cout1+cout2) for all 64 input patterns, and both of its sideways carries stay the same when only cin1 or cin2 changes.
- R11: The five-input compressor satisfies a+b+c+d+cin = sum + 2*(carry+cout) for all 32 input patterns, and its sideways carry stays the same when only cin changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the accumulator |
| clr | input | 1 | Synchronous clear; takes priority over enable |
| en | input | 1 | Load enable for the accumulate step |
| a_i | input | 8 | Unsigned multiplicand |
| b_i | input | 8 | Unsigned multiplier |
| acc_o | output | 17 | Accumulator register contents |

## Verification
The bench builds the core at its default operand width of 8 bits. At that width all 65,536 operand pairs can be swept against an arithmetic reference, each pair with a different addend that spreads over all sixteen addend positions. The two compressor cells are small enough to be driven through every input pattern. Each cell is also checked for sideways carries that do not depend on its carry-ins, which is what keeps the horizontal paths short. The accumulator is run through directed overflow steps and a long random mix of clear and enable, and is compared against a running 17-bit model that folds back only the low half.

// File: rtl/mac_merge_pkg.sv
package mac_merge_pkg;
    localparam int unsigned OPW  = 8;          // operand width
    localparam int unsigned ACCW = 2 * OPW;    // addend width
    localparam int unsigned RESW = 2 * OPW + 1; // result width
    localparam int unsigned HALF = OPW / 2;    // rows per first-level group
    localparam int unsigned COLS_S1 = OPW + HALF - 1; // columns per first-level group
    localparam int unsigned MOD_COL = OPW - 1; // first column holding a six-input cell

    function automatic logic xor3(input logic x, input logic y, input logic z);
        return x ^ y ^ z;
    endfunction

    function automatic logic maj3(input logic x, input logic y, input logic z);
        return (x & y) | (x & z) | (y & z);
    endfunction

    typedef struct packed {
        logic [RESW-1:0] acc;
    } acc_state_t;
endpackage

// File: rtl/mac_cmp42.sv
// Five-input compressor: four same-weight data bits and one carry-in.
// The sideways carry depends only on a, b and c.
module mac_cmp42 import mac_merge_pkg::*; (
    input  logic a,
    input  logic b,
    input  logic c,
    input  logic d,
    input  logic cin,
    output logic sum,
    output logic carry,
    output logic cout
);
    logic s1;

    always_comb begin
        s1    = xor3(a, b, c);
        cout  = maj3(a, b, c);
        sum   = xor3(s1, d, cin);
        carry = maj3(s1, d, cin);
    end
endmodule

// File: rtl/mac_cmp42x.sv
// Six-input compressor: four data bits plus two same-weight carry-ins.
// It has one upward carry and two sideways carries, both independent of the carry-ins.
module mac_cmp42x import mac_merge_pkg::*; (
    input  logic a,
    input  logic b,
    input  logic c,
    input  logic d,
    input  logic cin1,
    input  logic cin2,
    output logic sum,
    output logic carry,
    output logic cout1,
    output logic cout2
);
    logic s1;
    logic s2;

    always_comb begin
        s1    = xor3(a, b, c);
        cout1 = maj3(a, b, c);
        s2    = s1 ^ d;
        cout2 = s1 & d;
        sum   = xor3(s2, cin1, cin2);
        carry = maj3(s2, cin1, cin2);
    end
endmodule

// File: rtl/mac_cmp_row.sv
// One row of compressors, one per column. When MOD_AT >= 0, columns MOD_AT and
// MOD_AT+1 are six-input cells. The column above them takes both sideways carries
// in its d and cin slots, so its own d slot must be left empty by the caller.
// The extra bit xbit feeds the lower six-input cell, or column 0's carry-in when
// the row has no six-input cells.
module mac_cmp_row import mac_merge_pkg::*; #(
    parameter int COLS   = 11,
    parameter int MOD_AT = -1
) (
    input  logic [COLS-1:0][3:0] din,
    input  logic                 xbit,
    output logic [COLS-1:0]      sum_o,
    output logic [COLS-1:0]      carry_o,
    output logic                 spill_o
);
    logic [COLS-1:0] hc1;
    logic [COLS-1:0] hc2;

    for (genvar k = 0; k < COLS; k++) begin : g_col
        if (MOD_AT >= 0 && k == MOD_AT) begin : g_mod_lo
            mac_cmp42x u_cell (
                .a(din[k][0]), .b(din[k][1]), .c(din[k][2]), .d(din[k][3]),
                .cin1(xbit), .cin2(hc1[k-1]),
                .sum(sum_o[k]), .carry(carry_o[k]),
                .cout1(hc1[k]), .cout2(hc2[k])
            );
        end else if (MOD_AT >= 0 && k == MOD_AT + 1) begin : g_mod_hi
            mac_cmp42x u_cell (
                .a(din[k][0]), .b(din[k][1]), .c(din[k][2]), .d(din[k][3]),
                .cin1(hc1[k-1]), .cin2(hc2[k-1]),
                .sum(sum_o[k]), .carry(carry_o[k]),
                .cout1(hc1[k]), .cout2(hc2[k])
            );
        end else if (MOD_AT >= 0 && k == MOD_AT + 2) begin : g_absorb
            logic unused_slot;
            assign unused_slot = din[k][3];
            mac_cmp42 u_cell (
                .a(din[k][0]), .b(din[k][1]), .c(din[k][2]),
                .d(hc1[k-1]), .cin(hc2[k-1]),
                .sum(sum_o[k]), .carry(carry_o[k]), .cout(hc1[k])
            );
            assign hc2[k] = 1'b0;
        end else begin : g_reg
            logic cin_w;
            if (k == 0) begin : g_first
                assign cin_w = (MOD_AT < 0) ? xbit : 1'b0;
            end else begin : g_next
                assign cin_w = hc1[k-1];
            end
            mac_cmp42 u_cell (
                .a(din[k][0]), .b(din[k][1]), .c(din[k][2]), .d(din[k][3]),
                .cin(cin_w),
                .sum(sum_o[k]), .carry(carry_o[k]), .cout(hc1[k])
            );
            assign hc2[k] = 1'b0;
        end
    end

    logic unused_hc2;
    assign unused_hc2 = ^hc2;
    assign spill_o    = hc1[COLS-1] | hc2[COLS-1];
endmodule

// File: rtl/mac_merge_tree.sv
// Combinational merged multiply-add: res_o = a_i*b_i + z_i.
// Slots inside a column: 0=a, 1=b, 2=c, 3=d. The AND rows are packed so that the
// top column of each row has at most one bit among a/b/c, which keeps its sideways
// carry at zero.
module mac_merge_tree import mac_merge_pkg::*; (
    input  logic [OPW-1:0]  a_i,
    input  logic [OPW-1:0]  b_i,
    input  logic [ACCW-1:0] z_i,
    output logic [RESW-1:0] res_o,
    output logic            spill_o
);
    // first level, low group (rows 0..HALF-1) and high group (rows HALF..OPW-1)
    logic [COLS_S1-1:0][3:0] da;
    logic [COLS_S1-1:0][3:0] db;
    logic                    xa;
    logic [COLS_S1-1:0]      sa, ca, sb, cb;
    logic                    spa, spb;

    always_comb begin
        da = '0;
        db = '0;
        for (int i = 0; i < HALF; i++) begin
            for (int j = 0; j < OPW; j++) begin
                da[i+j][HALF-1-i] = a_i[j] & b_i[i];
            end
        end
        for (int i = HALF; i < OPW; i++) begin
            for (int j = 0; j < OPW; j++) begin
                db[i+j-HALF][OPW-1-i] = a_i[j] & b_i[i];
            end
        end
        // addend bits in the empty first-level slots, low group
        da[0][0]  = z_i[0];
        da[1][0]  = z_i[1];
        da[2][0]  = z_i[2];
        da[8][3]  = z_i[8];
        da[9][2]  = z_i[9];
        da[10][3] = z_i[10];
        xa        = z_i[7];   // fifth bit of the full column, absorbed by the six-input cell
        // high group, column index = weight - HALF
        db[1][0]  = z_i[5];
        db[2][0]  = z_i[6];
        db[8][3]  = z_i[12];
        db[9][2]  = z_i[13];
        db[10][3] = z_i[14];
    end

    mac_cmp_row #(.COLS(COLS_S1), .MOD_AT(MOD_COL)) u_lvl1_lo (
        .din(da), .xbit(xa), .sum_o(sa), .carry_o(ca), .spill_o(spa)
    );

    mac_cmp_row #(.COLS(COLS_S1), .MOD_AT(-1)) u_lvl1_hi (
        .din(db), .xbit(1'b0), .sum_o(sb), .carry_o(cb), .spill_o(spb)
    );

    // second level: align the four rows by weight
    logic [ACCW-1:0]      wsa, wca, wsb, wcb;
    logic [ACCW-1:0][3:0] d2;
    logic [ACCW-1:0]      s2s, s2c;
    logic                 sp2;

    assign wsa = {{(ACCW-COLS_S1){1'b0}}, sa};
    assign wca = {{(ACCW-COLS_S1-1){1'b0}}, ca, 1'b0};
    assign wsb = {{(ACCW-COLS_S1-HALF){1'b0}}, sb, {HALF{1'b0}}};
    assign wcb = {cb, {(HALF+1){1'b0}}};

    always_comb begin
        for (int w = 0; w < ACCW; w++) begin
            d2[w] = {wcb[w], wsb[w], wca[w], wsa[w]};
        end
        // remaining addend bits in the second-level gaps
        d2[3][2]  = z_i[3];
        d2[4][3]  = z_i[4];
        d2[11][0] = z_i[11];
        d2[15][0] = z_i[15];
    end

    mac_cmp_row #(.COLS(ACCW), .MOD_AT(-1)) u_lvl2 (
        .din(d2), .xbit(1'b0), .sum_o(s2s), .carry_o(s2c), .spill_o(sp2)
    );

    // single carry-propagate adder on the two remaining rows
    assign res_o   = {1'b0, s2s} + {s2c, 1'b0};
    assign spill_o = spa | spb | sp2;
endmodule

// File: rtl/mac_merge_acc.sv
module mac_merge_acc import mac_merge_pkg::*; (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            en,
    input  logic [OPW-1:0]  a_i,
    input  logic [OPW-1:0]  b_i,
    output logic [RESW-1:0] acc_o
);
    acc_state_t      state_d;
    acc_state_t      state_q;
    logic [RESW-1:0] tree_res;
    logic            tree_spill;

    mac_merge_tree u_tree (
        .a_i    (a_i),
        .b_i    (b_i),
        .z_i    (state_q.acc[ACCW-1:0]),
        .res_o  (tree_res),
        .spill_o(tree_spill)
    );

    always_comb begin
        state_d = state_q;
        if (clr) begin
            state_d.acc = '0;
        end else if (en) begin
            state_d.acc = tree_res;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign acc_o = state_q.acc;
endmodule

// File: rtl/mac_merge_acc_chk.sv
module mac_merge_acc_chk import mac_merge_pkg::*; (
    input logic            clk,
    input logic            rst_n,
    input logic            clr,
    input logic            en,
    input logic [OPW-1:0]  a_i,
    input logic [OPW-1:0]  b_i,
    input logic [RESW-1:0] acc_o,
    input logic            spill
);
    localparam logic [RESW-1:0] ACC_MAX =
        RESW'((2**OPW - 1) * (2**OPW - 1) + (2**ACCW - 1));

    assert_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && en) |=> acc_o == (RESW'($past(a_i)) * RESW'($past(b_i))
                                   + RESW'($past(acc_o[ACCW-1:0]))));

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !en) |=> $stable(acc_o));

    assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> acc_o == '0);

    assert_ceiling_R8: assert property (@(posedge clk) disable iff (!rst_n)
        acc_o <= ACC_MAX);

    assert_no_spill_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !spill);
endmodule

bind mac_merge_acc mac_merge_acc_chk u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (clr),
    .en   (en),
    .a_i  (a_i),
    .b_i  (b_i),
    .acc_o(acc_o),
    .spill(tree_spill)
);

// File: tb/mac_merge_acc_tb.sv
module mac_merge_acc_tb;
    import mac_merge_pkg::*;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // accumulator under test
    logic            rst_n, clr, en;
    logic [OPW-1:0]  a, b;
    logic [RESW-1:0] acc;

    mac_merge_acc u_dut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .en(en),
        .a_i(a), .b_i(b), .acc_o(acc)
    );

    // bare core for the operand sweeps
    logic [OPW-1:0]  ta, tb;
    logic [ACCW-1:0] tz;
    logic [RESW-1:0] tres;
    logic            tspill;

    mac_merge_tree u_tree (
        .a_i(ta), .b_i(tb), .z_i(tz), .res_o(tres), .spill_o(tspill)
    );

    // compressor cells
    logic p_a, p_b, p_c, p_d, p_cin, p_s, p_cy, p_co;
    mac_cmp42 u_c42 (
        .a(p_a), .b(p_b), .c(p_c), .d(p_d), .cin(p_cin),
        .sum(p_s), .carry(p_cy), .cout(p_co)
    );

    logic q_a, q_b, q_c, q_d, q_c1, q_c2, q_s, q_cy, q_o1, q_o2;
    mac_cmp42x u_c42x (
        .a(q_a), .b(q_b), .c(q_c), .d(q_d), .cin1(q_c1), .cin2(q_c2),
        .sum(q_s), .carry(q_cy), .cout1(q_o1), .cout2(q_o2)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    longint ref_acc = 0;

    // drive one cycle at the falling edge, check at the next falling edge
    task automatic step(input string req, input int av, input int bv,
                        input bit e, input bit c);
        a   = OPW'(av);
        b   = OPW'(bv);
        en  = e;
        clr = c;
        if (c) ref_acc = 0;
        else if (e) ref_acc = longint'(av) * longint'(bv) + (ref_acc & 64'hFFFF);
        @(negedge clk);
        chk(req, longint'(acc), ref_acc);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog (all requirements): actual 200000 cycles expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; clr = 1'b0; en = 1'b0; a = '0; b = '0;
        ta = '0; tb = '0; tz = '0;
        {p_a, p_b, p_c, p_d, p_cin} = '0;
        {q_a, q_b, q_c, q_d, q_c1, q_c2} = '0;
        repeat (3) @(posedge clk);
        #1;
        chk("R4 during reset", longint'(acc), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R4 after release", longint'(acc), 0);

        // R11: five-input cell, every pattern; sideways carry blind to cin
        for (int v = 0; v < 16; v++) begin
            logic co0;
            {p_a, p_b, p_c, p_d} = 4'(v);
            p_cin = 1'b0;
            #1;
            co0 = p_co;
            chk("R11 weight sum cin=0", int'(p_s) + 2 * (int'(p_cy) + int'(p_co)),
                $countones(v));
            p_cin = 1'b1;
            #1;
            chk("R11 weight sum cin=1", int'(p_s) + 2 * (int'(p_cy) + int'(p_co)),
                $countones(v) + 1);
            chk("R11 cout independent of cin", int'(p_co), int'(co0));
        end

        // R10: six-input cell, every pattern; both sideways carries blind to carry-ins
        for (int v = 0; v < 16; v++) begin
            logic o1_ref, o2_ref;
            {q_a, q_b, q_c, q_d} = 4'(v);
            {q_c1, q_c2} = 2'b00;
            #1;
            o1_ref = q_o1;
            o2_ref = q_o2;
            for (int ci = 0; ci < 4; ci++) begin
                {q_c1, q_c2} = 2'(ci);
                #1;
                chk("R10 weight sum",
                    int'(q_s) + 2 * (int'(q_cy) + int'(q_o1) + int'(q_o2)),
                    $countones(v) + $countones(ci));
                chk("R10 cout1 independent of carry-ins", int'(q_o1), int'(o1_ref));
                chk("R10 cout2 independent of carry-ins", int'(q_o2), int'(o2_ref));
            end
        end

        // R1 / R9: every operand pair, addend varied per pair
        for (int ia = 0; ia < 256; ia++) begin
            for (int ib = 0; ib < 256; ib++) begin
                int zv;
                zv = (ia * 40503 + ib * 9973 + ((ia ^ ib) << 7)) & 16'hFFFF;
                ta = 8'(ia);
                tb = 8'(ib);
                tz = 16'(zv);
                #1;
                chk("R1 product plus addend", longint'(tres), longint'(ia * ib + zv));
                chk("R9 no top-column spill", longint'(tspill), 0);
            end
        end

        // R2: each addend bit carries weight 2^k
        for (int k = 0; k < 16; k++) begin
            ta = 8'd0; tb = 8'd0; tz = 16'(1 << k);
            #1;
            chk("R2 addend bit, zero operands", longint'(tres), longint'(1 << k));
            ta = 8'd255; tb = 8'd255;
            #1;
            chk("R2 addend bit, full operands", longint'(tres), longint'(65025 + (1 << k)));
        end

        // R3: tallest column fully loaded
        ta = 8'd255; tb = 8'd255; tz = 16'hFFFF;
        #1;
        chk("R3 maximum result", longint'(tres), 130560);
        chk("R3 top bit set", longint'(tres[16]), 1);

        // accumulator directed steps
        @(negedge clk);
        step("R5 first load", 3, 5, 1'b1, 1'b0);           // 15
        step("R6 hold with enable low", 200, 100, 1'b0, 1'b0);
        step("R7 clear beats enable", 7, 7, 1'b1, 1'b1);   // 0
        step("R5 load from zero", 255, 255, 1'b1, 1'b0);   // 65025
        step("R8 overflow into bit 16", 255, 255, 1'b1, 1'b0); // 130050
        chk("R8 bit 16 set", longint'(acc[16]), 1);
        step("R8 low half fed back", 255, 255, 1'b1, 1'b0);    // 129539
        step("R7 clear with enable low", 9, 9, 1'b0, 1'b1);
        step("R6 hold at zero", 9, 9, 1'b0, 1'b0);

        // random mix of clear and enable
        for (int n = 0; n < 3000; n++) begin
            int r;
            bit e, c;
            r = int'($urandom);
            e = (r[1:0] != 2'b00);
            c = (r[7:4] == 4'h0);
            step(c ? "R7 random clear" : (e ? "R5 random load" : "R6 random hold"),
                 int'($urandom % 256), int'($urandom % 256), e, c);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule